// File: doc/BRIEF.md
# Halfword Lane Bridge

This block sits between a processor bus that issues byte, halfword and word accesses and a register bank that only accepts halfword transfers. It checks each processor request against a fixed address range. Requests that fall inside the range are turned into one or two halfword transactions on a valid/ready port. Requests outside the range go to a second, default target without any change.

Read results come back at the width the processor asked for. A byte read fetches the containing halfword and picks one lane. A word read joins two halfwords, the lower address first. Byte writes have only one legal lane. A byte write to an odd address completes on the processor side, but the register bank never sees it.

The processor holds its request steady until it sees ready. Ready for an in-range access rises for exactly one cycle, after the last peripheral transaction has finished. The peripheral returns read data on the cycle that follows its handshake.

Top module: `halfword_bridge`

## Requirements
- R1: Address bits 31:29 are cleared before decode, so every mirror of the range reaches the peripheral. The peripheral address then has bits 31:29 at zero.
- R2: An access hits when its masked address is at least 0x1F801C00 and below 0x1F802000. Any other address never produces a peripheral transaction.
- R3: A miss is forwarded to the default port with request, write, size, the full unmasked address and write data unchanged. The default port's ready and read data are returned to the processor.
- R4: Size encoding is 0 for byte, 1 for halfword, 2 for word (3 is treated as word). A byte read makes one halfword read at the address with bit 0 cleared. It returns bits 15:8 of that halfword when address bit 0 is 1, and bits 7:0 otherwise, zero-extended to 32 bits.
- R5: A byte write to an odd address makes no peripheral transaction, and the processor access still completes.
- R6: A byte write to an even address makes one halfword write whose data is {8'h00, data[7:0]}.
- R7: A halfword access makes one transaction at the address with bit 0 cleared. A halfword read returns the data zero-extended to 32 bits.
- R8: A word read makes two halfword reads, at the address and then at the address plus 2. The first result lands in bits 15:0 and the second in bits 31:16.
- R9: A word write makes two halfword writes: bits 15:0 to the address, then bits 31:16 to the address plus 2.
- R10: Processor ready for a hit is high for one cycle, only after the last transaction (and, for a read, its data cycle). While the peripheral stalls, valid, address, write flag and write data stay stable.
- R11: After reset, no peripheral transaction is pending and processor ready is low while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuReq | input | 1 | Processor request, held until ready |
| cpuWe | input | 1 | Processor write (1) or read (0) |
| cpuSize | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| cpuAddr | input | 32 | Processor byte address |
| cpuWdata | input | 32 | Processor write data, right-aligned |
| cpuRdata | output | 32 | Read data, valid with cpuReady |
| cpuReady | output | 1 | Access complete |
| perValid | output | 1 | Peripheral transaction valid |
| perWe | output | 1 | Peripheral write flag |
| perAddr | output | 32 | Peripheral halfword address (bit 0 zero) |
| perWdata | output | 16 | Peripheral write data |
| perReady | input | 1 | Peripheral accepts the transaction |
| perRdata | input | 16 | Peripheral read data, cycle after a read handshake |
| dfltReq | output | 1 | Request to the default target |
| dfltWe | output | 1 | Default target write flag |
| dfltSize | output | 2 | Default target access size |
| dfltAddr | output | 32 | Default target address, unmasked |
| dfltWdata | output | 32 | Default target write data |
| dfltRdata | input | 32 | Default target read data |
| dfltReady | input | 1 | Default target done |

## Verification
The bench probes the range edges on both sides: one halfword below the base, the last halfword inside, and the limit itself. An off-by-one compare would send one of these to the wrong port. It issues byte reads at both lanes and byte writes at both parities. A swapped lane select returns the wrong byte, and a missing odd-write filter shows up as a stray transaction in the peripheral log. Word accesses run with a stalling peripheral. This exposes reversed halfword order, a high half taken from the wrong cycle, and a ready raised before the second read's data has arrived. That last fault shows up as a short latency count or stale upper bits. A mirrored address checks that the top bits are dropped for the peripheral but kept for the default target.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO_REQ,
    ST_LO_DATA,
    ST_HI_REQ,
    ST_HI_DATA,
    ST_DONE
  } laneState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // latch the new processor access
    logic hiSel;  // upper halfword phase
    logic capLo;  // capture first returned halfword
    logic capHi;  // capture second returned halfword
  } laneStrobe_t;

endpackage

// File: rtl/hb_decode.sv
module hb_decode #(
  parameter int          ADDR_W      = 32,
  parameter int          MIRROR_BITS = 3,
  parameter logic [31:0] WIN_BASE    = 32'h1F80_1C00,
  parameter logic [31:0] WIN_LIMIT   = 32'h1F80_2000
) (
  input  logic [ADDR_W-1:0] rawAddr,
  output logic [ADDR_W-1:0] physAddr,
  output logic              hit
);
  localparam int KEEP_W = ADDR_W - MIRROR_BITS;

  // top bits dropped so every mirror lands on the same window
  assign physAddr = {{MIRROR_BITS{1'b0}}, rawAddr[KEEP_W-1:0]};
  assign hit = (physAddr >= WIN_BASE[ADDR_W-1:0]) && (physAddr < WIN_LIMIT[ADDR_W-1:0]);

endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        reqWe,
  input  logic [1:0]  reqSize,
  input  logic        reqOdd,
  input  logic        perReady,
  output logic        perValid,
  output logic        perWe,
  output logic        winDone,
  output laneStrobe_t strobe
);
  laneState_e state;
  logic isWrite;
  logic isWord;
  logic dropWr;

  logic startDrop;
  assign startDrop = reqWe && (reqSize == SZ_BYTE) && reqOdd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isWrite <= 1'b0;
      isWord  <= 1'b0;
      dropWr  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            isWrite <= reqWe;
            isWord  <= reqSize[1];
            dropWr  <= startDrop;
            state   <= startDrop ? ST_DONE : ST_LO_REQ;
          end
        end
        ST_LO_REQ: begin
          if (perReady) begin
            if (!isWrite)     state <= ST_LO_DATA;
            else if (isWord)  state <= ST_HI_REQ;
            else              state <= ST_DONE;
          end
        end
        ST_LO_DATA: state <= isWord ? ST_HI_REQ : ST_DONE;
        ST_HI_REQ: begin
          if (perReady) state <= isWrite ? ST_DONE : ST_HI_DATA;
        end
        ST_HI_DATA: state <= ST_DONE;
        ST_DONE:    state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.load  = (state == ST_IDLE) && startReq;
    strobe.hiSel = (state == ST_HI_REQ) || (state == ST_HI_DATA);
    strobe.capLo = (state == ST_LO_DATA);
    strobe.capHi = (state == ST_HI_DATA);
  end

  assign perValid = (state == ST_LO_REQ) || (state == ST_HI_REQ);
  assign perWe    = isWrite;
  assign winDone  = (state == ST_DONE);

  // checker: handshakes since the access started
  logic [1:0] hsCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      hsCnt <= '0;
    else if (state == ST_IDLE)      hsCnt <= '0;
    else if (perValid && perReady)  hsCnt <= hsCnt + 2'd1;
  end

  // R10 / R5: completion only after the expected number of transactions
  assert_done_after_all_R10: assert property (@(posedge clk) disable iff (!rstN)
    winDone |-> (hsCnt == (isWord ? 2'd2 : (dropWr ? 2'd0 : 2'd1))));

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    winDone |=> !winDone);

  // R5: a dropped write never reaches the peripheral
  assert_drop_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    dropWr && !winDone |-> !perValid);

endmodule

// File: rtl/hb_datapath.sv
module hb_datapath
  import hb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobe_t       strobe,
  input  logic [ADDR_W-1:0] physAddr,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W/2-1:0] perRdata,
  output logic [ADDR_W-1:0] perAddr,
  output logic [DATA_W/2-1:0] perWdata,
  output logic [DATA_W-1:0] rdData
);
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = HALF_W / 2;
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(HALF_W / 8);

  logic [ADDR_W-1:0] accAddr;
  logic [1:0]        accSize;
  logic [DATA_W-1:0] accWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accAddr  <= '0;
      accSize  <= '0;
      accWdata <= '0;
      rdData   <= '0;
    end else begin
      if (strobe.load) begin
        accAddr  <= physAddr;
        accSize  <= reqSize;
        accWdata <= reqWdata;
        rdData   <= '0;
      end
      if (strobe.capLo) begin
        unique case (accSize)
          SZ_BYTE: rdData <= {{(DATA_W-BYTE_W){1'b0}},
                              accAddr[0] ? perRdata[HALF_W-1:BYTE_W] : perRdata[BYTE_W-1:0]};
          SZ_HALF: rdData <= {{HALF_W{1'b0}}, perRdata};
          default: rdData[HALF_W-1:0] <= perRdata;
        endcase
      end
      if (strobe.capHi) rdData[DATA_W-1:HALF_W] <= perRdata;
    end
  end

  logic [ADDR_W-1:0] evenAddr;
  assign evenAddr = {accAddr[ADDR_W-1:1], 1'b0};
  assign perAddr  = strobe.hiSel ? evenAddr + HALF_STEP : evenAddr;

  always_comb begin
    if (strobe.hiSel)             perWdata = accWdata[DATA_W-1:HALF_W];
    else if (accSize == SZ_BYTE)  perWdata = {{BYTE_W{1'b0}}, accWdata[BYTE_W-1:0]};
    else                          perWdata = accWdata[HALF_W-1:0];
  end

  // R8: the second phase always addresses the following halfword
  assert_hi_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capHi |-> perAddr[1] != accAddr[1] || perAddr[ADDR_W-1:2] != accAddr[ADDR_W-1:2]);

endmodule

// File: rtl/halfword_bridge.sv
module halfword_bridge
  import hb_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          MIRROR_BITS = 3,
  parameter logic [31:0] WIN_BASE    = 32'h1F80_1C00,
  parameter logic [31:0] WIN_LIMIT   = 32'h1F80_2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [1:0]        cpuSize,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              perValid,
  output logic              perWe,
  output logic [ADDR_W-1:0] perAddr,
  output logic [DATA_W/2-1:0] perWdata,
  input  logic              perReady,
  input  logic [DATA_W/2-1:0] perRdata,
  output logic              dfltReq,
  output logic              dfltWe,
  output logic [1:0]        dfltSize,
  output logic [ADDR_W-1:0] dfltAddr,
  output logic [DATA_W-1:0] dfltWdata,
  input  logic [DATA_W-1:0] dfltRdata,
  input  logic              dfltReady
);
  logic [ADDR_W-1:0] physAddr;
  logic              hit;
  logic              winDone;
  logic [DATA_W-1:0] winRdata;
  laneStrobe_t       strobe;

  hb_decode #(
    .ADDR_W(ADDR_W), .MIRROR_BITS(MIRROR_BITS),
    .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT)
  ) u_decode (
    .rawAddr(cpuAddr), .physAddr(physAddr), .hit(hit)
  );

  hb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReq(cpuReq && hit), .reqWe(cpuWe), .reqSize(cpuSize), .reqOdd(cpuAddr[0]),
    .perReady(perReady), .perValid(perValid), .perWe(perWe),
    .winDone(winDone), .strobe(strobe)
  );

  hb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .physAddr(physAddr), .reqSize(cpuSize), .reqWdata(cpuWdata),
    .perRdata(perRdata), .perAddr(perAddr), .perWdata(perWdata), .rdData(winRdata)
  );

  // out-of-window traffic goes straight through
  assign dfltReq   = cpuReq && !hit;
  assign dfltWe    = cpuWe;
  assign dfltSize  = cpuSize;
  assign dfltAddr  = cpuAddr;
  assign dfltWdata = cpuWdata;

  assign cpuReady = cpuReq && (hit ? winDone : dfltReady);
  assign cpuRdata = hit ? winRdata : dfltRdata;

  assert_mirror_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    perValid |-> perAddr[ADDR_W-1:ADDR_W-MIRROR_BITS] == '0);

  assert_in_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    perValid |-> (perAddr >= WIN_BASE[ADDR_W-1:0]) && (perAddr < WIN_LIMIT[ADDR_W-1:0]));

  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    perValid |-> !dfltReq);

  assert_odd_byte_wr_R5: assert property (@(posedge clk) disable iff (!rstN)
    perValid && cpuReq && cpuWe && cpuSize == SZ_BYTE |-> !cpuAddr[0]);

  assert_even_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    perValid |-> !perAddr[0]);

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rstN)
    perValid && !perReady |=> perValid && $stable(perAddr) && $stable(perWe) && $stable(perWdata));

endmodule

// File: tb/halfword_bridge_tb.sv
module halfword_bridge_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [1:0]  cpuSize = 2'd0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        cpuReady;
  logic        perValid, perWe;
  logic [31:0] perAddr;
  logic [15:0] perWdata;
  logic        perReady;
  logic [15:0] perRdata = '0;
  logic        dfltReq, dfltWe;
  logic [1:0]  dfltSize;
  logic [31:0] dfltAddr, dfltWdata, dfltRdata;
  logic        dfltReady;

  halfword_bridge u_dut (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuSize(cpuSize), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .perValid(perValid), .perWe(perWe), .perAddr(perAddr), .perWdata(perWdata),
    .perReady(perReady), .perRdata(perRdata),
    .dfltReq(dfltReq), .dfltWe(dfltWe), .dfltSize(dfltSize), .dfltAddr(dfltAddr),
    .dfltWdata(dfltWdata), .dfltRdata(dfltRdata), .dfltReady(dfltReady)
  );

  int errors = 0;
  int checks = 0;

  // peripheral model: programmable stall, data one cycle after a read handshake
  int stall = 0;
  int waitCnt = 0;
  assign perReady = perValid && (waitCnt == stall);

  int          logN = 0;
  logic        logWe   [8];
  logic [31:0] logAddr [8];
  logic [15:0] logData [8];

  function automatic logic [15:0] perFn(logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  always @(posedge clk) begin
    if (perValid && perReady) begin
      waitCnt <= 0;
      if (logN < 8) begin
        logWe[logN]   = perWe;
        logAddr[logN] = perAddr;
        logData[logN] = perWdata;
      end
      logN = logN + 1;
      if (!perWe) perRdata <= perFn(perAddr);
    end else if (perValid) begin
      waitCnt <= waitCnt + 1;
    end
  end

  // default target model
  assign dfltReady = dfltReq;
  assign dfltRdata = dfltAddr ^ 32'hC3C3_0F0F;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [31:0] wd, input int stl,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    stall = stl;
    logN = 0;
    cpuReq = 1'b1; cpuWe = we; cpuSize = sz; cpuAddr = addr; cpuWdata = wd;
    cyc = 0;
    rd = '0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cpuReady) begin
        rd = cpuRdata;
        break;
      end
      if (cyc > 1000) begin
        chk(1'b0, "watchdog", 32'(cyc), 32'd1000);
        break;
      end
    end
    cpuReq = 1'b0;
  endtask

  task automatic tReset();
    chk(!perValid, "R11 perValid after reset", 32'(perValid), 0);
    chk(!cpuReady, "R11 cpuReady after reset", 32'(cpuReady), 0);
    chk(!dfltReq,  "R11 dfltReq after reset", 32'(dfltReq), 0);
  endtask

  task automatic tByteRead();
    logic [31:0] rd; int cyc;
    access(1'b0, 2'd0, 32'h1F80_1C05, 0, 0, rd, cyc);
    chk(rd == {24'h0, perFn(32'h1F80_1C04)[15:8]}, "R4 odd byte read", rd, {24'h0, perFn(32'h1F80_1C04)[15:8]});
    chk(logN == 1 && logAddr[0] == 32'h1F80_1C04 && !logWe[0], "R4 odd byte read txn", logAddr[0], 32'h1F80_1C04);
    access(1'b0, 2'd0, 32'h1F80_1C04, 0, 2, rd, cyc);
    chk(rd == {24'h0, perFn(32'h1F80_1C04)[7:0]}, "R4 even byte read", rd, {24'h0, perFn(32'h1F80_1C04)[7:0]});
  endtask

  task automatic tByteWrite();
    logic [31:0] rd; int cyc;
    access(1'b1, 2'd0, 32'h1F80_1D21, 32'hFFFF_FFAB, 0, rd, cyc);
    chk(logN == 0, "R5 odd byte write dropped", 32'(logN), 0);
    chk(cyc == 1, "R5 odd byte write completes", 32'(cyc), 1);
    access(1'b1, 2'd0, 32'h1F80_1D20, 32'hFFFF_FFAB, 1, rd, cyc);
    chk(logN == 1 && logWe[0] && logAddr[0] == 32'h1F80_1D20, "R6 even byte write addr", logAddr[0], 32'h1F80_1D20);
    chk(logData[0] == 16'h00AB, "R6 even byte write data", 32'(logData[0]), 32'h00AB);
  endtask

  task automatic tHalf();
    logic [31:0] rd; int cyc;
    access(1'b1, 2'd1, 32'h1F80_1E42, 32'hDEAD_1234, 3, rd, cyc);
    chk(logN == 1 && logData[0] == 16'h1234 && logAddr[0] == 32'h1F80_1E42, "R7 half write", 32'(logData[0]), 32'h1234);
    chk(cyc == 5, "R10 half write latency stall3", 32'(cyc), 5);
    access(1'b0, 2'd1, 32'h1F80_1E43, 0, 0, rd, cyc);
    chk(rd == {16'h0, perFn(32'h1F80_1E42)}, "R7 half read", rd, {16'h0, perFn(32'h1F80_1E42)});
    chk(logN == 1 && logAddr[0] == 32'h1F80_1E42, "R7 half read addr even", logAddr[0], 32'h1F80_1E42);
  endtask

  task automatic tWord();
    logic [31:0] rd; int cyc; logic [31:0] exp;
    access(1'b0, 2'd2, 32'h1F80_1C80, 0, 1, rd, cyc);
    exp = {perFn(32'h1F80_1C82), perFn(32'h1F80_1C80)};
    chk(rd == exp, "R8 word read data", rd, exp);
    chk(logN == 2 && logAddr[0] == 32'h1F80_1C80 && logAddr[1] == 32'h1F80_1C82, "R8 word read order", logAddr[1], 32'h1F80_1C82);
    chk(cyc == 7, "R10 word read latency stall1", 32'(cyc), 7);
    access(1'b1, 2'd2, 32'h1F80_1FF0, 32'hCAFE_BEEF, 2, rd, cyc);
    chk(logN == 2 && logData[0] == 16'hBEEF && logAddr[0] == 32'h1F80_1FF0, "R9 word write low first", 32'(logData[0]), 32'hBEEF);
    chk(logData[1] == 16'hCAFE && logAddr[1] == 32'h1F80_1FF2, "R9 word write high second", 32'(logData[1]), 32'hCAFE);
  endtask

  task automatic tMirror();
    logic [31:0] rd; int cyc; logic [31:0] exp;
    access(1'b0, 2'd2, 32'hBF80_1C10, 0, 0, rd, cyc);
    exp = {perFn(32'h1F80_1C12), perFn(32'h1F80_1C10)};
    chk(logN == 2 && logAddr[0] == 32'h1F80_1C10, "R1 mirror masked addr", logAddr[0], 32'h1F80_1C10);
    chk(rd == exp, "R1 mirror read data", rd, exp);
  endtask

  task automatic tBounds();
    logic [31:0] rd; int cyc;
    access(1'b0, 2'd1, 32'h1F80_1BFE, 0, 0, rd, cyc);
    chk(logN == 0 && rd == (32'h1F80_1BFE ^ 32'hC3C3_0F0F), "R2 below base is miss", rd, 32'h1F80_1BFE ^ 32'hC3C3_0F0F);
    access(1'b0, 2'd1, 32'h1F80_2000, 0, 0, rd, cyc);
    chk(logN == 0 && rd == (32'h1F80_2000 ^ 32'hC3C3_0F0F), "R2 limit is miss", rd, 32'h1F80_2000 ^ 32'hC3C3_0F0F);
    access(1'b0, 2'd1, 32'h1F80_1FFE, 0, 0, rd, cyc);
    chk(logN == 1 && rd == {16'h0, perFn(32'h1F80_1FFE)}, "R2 last halfword hits", rd, {16'h0, perFn(32'h1F80_1FFE)});
    access(1'b0, 2'd1, 32'h1F80_1C00, 0, 0, rd, cyc);
    chk(logN == 1 && logAddr[0] == 32'h1F80_1C00, "R2 base hits", logAddr[0], 32'h1F80_1C00);
  endtask

  task automatic tDefault();
    @(negedge clk);
    logN = 0;
    cpuReq = 1'b1; cpuWe = 1'b1; cpuSize = 2'd0; cpuAddr = 32'hA000_1235; cpuWdata = 32'h1122_3344;
    #1;
    chk(dfltReq && dfltWe && dfltSize == 2'd0, "R3 default ctrl passthrough", {29'h0, dfltReq, dfltSize}, 32'h4);
    chk(dfltAddr == 32'hA000_1235, "R3 default addr unchanged", dfltAddr, 32'hA000_1235);
    chk(dfltWdata == 32'h1122_3344, "R3 default data unchanged", dfltWdata, 32'h1122_3344);
    chk(cpuReady && cpuRdata == (32'hA000_1235 ^ 32'hC3C3_0F0F), "R3 default ready/rdata", cpuRdata, 32'hA000_1235 ^ 32'hC3C3_0F0F);
    @(negedge clk);
    chk(!perValid && logN == 0, "R3 no peripheral txn on miss", 32'(logN), 0);
    cpuReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tByteRead();
    tByteWrite();
    tHalf();
    tWord();
    tMirror();
    tBounds();
    tDefault();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule